// File: doc/BRIEF.md
# NVMe Key-Value Queue Initiator

This engine issues key-value Store and Retrieve commands over a single NVMe I/O queue pair. A client hands over one request at a time: operation, a key of up to 16 bytes with its length, a value size and a data buffer address. For each request the engine writes a 64-byte submission entry into the submission ring in memory, one dword per write handshake. The key travels inside the command. The buffer is described by the same two data pointers that a block read uses.

Requests build up into a batch. The batch closes when the client marks a request as last, or when it holds one entry less than the ring depth. The whole batch is then announced with a single submission tail doorbell write. The engine then polls the completion ring by phase bit. After every phase match it reads the entry a second time and only then trusts the returned length. It reports tag, status and value length for each completion in arrival order. It writes the completion head doorbell once the batch has drained. If a completion never arrives, a poll budget ends the wait and each outstanding request is reported with a timeout flag.

Memory writes, memory reads and register writes are simple valid/acknowledge ports. A port holds its request until the acknowledge cycle.

Top module: `kv_queue_initiator`

## Requirements
- R1: Submission dword 0 carries the opcode in bits [7:0] (0x01 when `req_op`=0 Store, 0x02 when `req_op`=1 Retrieve) and the command identifier in bits [31:16], equal to the submission slot index. Dword 1 carries the namespace parameter.
- R2: Key byte i (`req_key[8i+7:8i]`) is placed in dword 2 + i/4 for i < 8 and in dword 14 + (i−8)/4 for i ≥ 8, at byte i mod 4 of that dword. Dword 11 bits [7:0] hold the key length (1 to 16).
- R3: Dword 10 holds the value size in bytes. Dwords 6–7 hold the buffer address as the first data pointer, low dword first. Dwords 8–9 hold the next 4 KiB page address when the buffer crosses a page boundary, and zero otherwise. Dwords 4, 5, 12 and 13 are zero.
- R4: Entry dword d of slot s is written to sq_base + 64·s + 4·d, one dword per write handshake. Slots advance by one per request, modulo the ring depth.
- R5: A batch closes on a request marked last, or automatically at ring depth − 1 entries. It is announced by exactly one register write of the new tail to 0x1000 + 8·qid. No request is accepted while a batch is in flight.
- R6: The completion entry at cq_base + 16·head is a match when bit 16 of its dword 3 equals the expected phase. The expected phase is 1 after reset and inverts each time the head wraps.
- R7: After a match, the same entry is read again. The reported length is dword 0 of this second read, so a match costs exactly two reads.
- R8: Completions are reported in arrival order, with tag = command identifier and status = dword 3 bits [31:17]. This holds even when the controller completes the batch out of submission order.
- R9: After the last completion of a batch, exactly one register write of the new head goes to 0x1000 + 8·qid + 4.
- R10: After a poll budget of unmatched reads in a row, every outstanding request is reported with the timeout flag set, in ascending tag order. Then the head doorbell is written with the unchanged head and the engine returns to accepting requests.
- R11: After reset the engine accepts requests and drives no write, read, register or response valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 1 | 0 Store, 1 Retrieve |
| req_key | input | 128 | Key bytes, byte 0 in the low bits |
| req_key_len | input | 5 | Key length in bytes, 1 to 16 |
| req_value_size | input | 32 | Value size in bytes |
| req_dptr | input | 64 | Value buffer address |
| req_last | input | 1 | Closes the batch after this request |
| mem_wr_valid | output | 1 | Submission dword write request |
| mem_wr_addr | output | 64 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ack | input | 1 | Write accepted |
| mem_rd_valid | output | 1 | Completion entry read request |
| mem_rd_addr | output | 64 | Read byte address |
| mem_rd_data | input | 128 | Completion entry, valid with mem_rd_ack |
| mem_rd_ack | input | 1 | Read data returned |
| reg_wr_valid | output | 1 | Doorbell register write request |
| reg_wr_addr | output | 16 | Register offset |
| reg_wr_data | output | 32 | Doorbell value |
| reg_wr_ack | input | 1 | Register write accepted |
| rsp_valid | output | 1 | Completion report, one cycle |
| rsp_tag | output | $clog2(QDEPTH) | Request tag (submission slot) |
| rsp_len | output | 32 | Returned value length |
| rsp_status | output | 15 | Completion status |
| rsp_timeout | output | 1 | Request abandoned after poll budget |

## Verification
In one beat, the memory model can return a completion whose phase bit has just flipped while dword 0 still holds the stale value from before. So the phase match and the length capture fall on the same returned entry. The bench provokes this on Retrieve entries by handing back a zero length on the first visible read and the true length on every later one. It judges the result from the reported length and from the exact number of completion reads per batch. A second coincidence is checked as well: the head wraps in the middle of a batch that the model completes in reverse order. The expected phase must then invert between two reaps of the same batch, and the tags must follow completion order rather than submission order.

// File: rtl/kvq_pkg.sv
package kvq_pkg;

  localparam logic [7:0] OPC_STORE    = 8'h01;
  localparam logic [7:0] OPC_RETRIEVE = 8'h02;

  typedef struct packed {
    logic         op;
    logic [127:0] key;
    logic [4:0]   key_len;
    logic [31:0]  vsize;
    logic [63:0]  dptr;
  } kv_req_t;

  typedef enum logic [2:0] {
    S_IDLE, S_BUILD, S_RING_SQ, S_POLL, S_REREAD, S_REPORT, S_RING_CQ, S_TIMEOUT
  } kvq_state_e;

endpackage

// File: rtl/kvq_sqe_pack.sv
module kvq_sqe_pack
  import kvq_pkg::*;
#(
  parameter int          TAG_W = 4,
  parameter logic [31:0] NSID  = 32'h1
) (
  input  kv_req_t          req,
  input  logic [TAG_W-1:0] cid,
  input  logic [3:0]       idx,
  output logic [31:0]      dword
);

  logic        spans;
  logic [63:0] prp2;

  // second pointer only when the value runs past the first 4 KiB page
  always_comb begin
    spans = ({21'd0, req.dptr[11:0]} + {1'b0, req.vsize}) > 33'd4096;
    prp2  = spans ? {req.dptr[63:12] + 52'd1, 12'h000} : 64'd0;
  end

  always_comb begin
    unique case (idx)
      4'd0:    dword = {16'(cid), 8'h00, req.op ? OPC_RETRIEVE : OPC_STORE};
      4'd1:    dword = NSID;
      4'd2:    dword = req.key[31:0];
      4'd3:    dword = req.key[63:32];
      4'd6:    dword = req.dptr[31:0];
      4'd7:    dword = req.dptr[63:32];
      4'd8:    dword = prp2[31:0];
      4'd9:    dword = prp2[63:32];
      4'd10:   dword = req.vsize;
      4'd11:   dword = {27'd0, req.key_len};
      4'd14:   dword = req.key[95:64];
      4'd15:   dword = req.key[127:96];
      default: dword = 32'd0;
    endcase
  end

endmodule

// File: rtl/kvq_cq_ring.sv
module kvq_cq_ring #(
  parameter int QDEPTH     = 16,
  parameter int POLL_LIMIT = 100000,
  localparam int TAG_W     = $clog2(QDEPTH),
  localparam int PCNT_W    = $clog2(POLL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             miss_i,
  input  logic             clr_i,
  output logic [TAG_W-1:0] head_o,
  output logic             phase_o,
  output logic             expired_o
);

  logic [TAG_W-1:0]  head_q, head_d;
  logic              phase_q, phase_d;
  logic [PCNT_W-1:0] poll_q, poll_d;
  logic              wrap;

  always_comb begin
    wrap    = head_q == TAG_W'(QDEPTH - 1);
    head_d  = head_q;
    phase_d = phase_q;
    poll_d  = poll_q;
    if (adv_i) begin
      head_d  = wrap ? '0 : head_q + 1'b1;
      phase_d = wrap ? ~phase_q : phase_q;
    end
    if (clr_i)       poll_d = '0;
    else if (miss_i) poll_d = poll_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      phase_q <= 1'b1;
      poll_q  <= '0;
    end else begin
      if (adv_i)          head_q  <= head_d;
      if (adv_i)          phase_q <= phase_d;
      if (clr_i | miss_i) poll_q  <= poll_d;
    end
  end

  assign head_o    = head_q;
  assign phase_o   = phase_q;
  assign expired_o = poll_q == PCNT_W'(POLL_LIMIT - 1);

  // R6: a wrap of the head inverts the expected phase
  p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && wrap) |=> (phase_q != $past(phase_q)));

  // R10: the unmatched-read count never passes the budget
  p_poll_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PCNT_W'(POLL_LIMIT));

endmodule

// File: rtl/kvq_lowest.sv
module kvq_lowest #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end

endmodule

// File: rtl/kv_queue_initiator.sv
module kv_queue_initiator
  import kvq_pkg::*;
#(
  parameter int          QDEPTH       = 16,
  parameter int          QID          = 1,
  parameter logic [31:0] NSID         = 32'h1,
  parameter logic [63:0] SQ_BASE      = 64'h0000_0000_1000_0000,
  parameter logic [63:0] CQ_BASE      = 64'h0000_0000_2000_0000,
  parameter int          POLL_LIMIT   = 100000,
  parameter bit          HEAD_DB_EACH = 1'b0,
  localparam int         TAG_W        = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [127:0]      req_key,
  input  logic [4:0]        req_key_len,
  input  logic [31:0]       req_value_size,
  input  logic [63:0]       req_dptr,
  input  logic              req_last,
  output logic              mem_wr_valid,
  output logic [63:0]       mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              mem_rd_valid,
  output logic [63:0]       mem_rd_addr,
  input  logic [127:0]      mem_rd_data,
  input  logic              mem_rd_ack,
  output logic              reg_wr_valid,
  output logic [15:0]       reg_wr_addr,
  output logic [31:0]       reg_wr_data,
  input  logic              reg_wr_ack,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [31:0]       rsp_len,
  output logic [14:0]       rsp_status,
  output logic              rsp_timeout
);

  localparam logic [15:0] SQ_DB = 16'h1000 + 16'(8 * QID);
  localparam logic [15:0] CQ_DB = SQ_DB + 16'd4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  kvq_state_e        state_q, state_d;
  kv_req_t           req_q, req_d;
  logic              last_q, last_d;
  logic [TAG_W-1:0]  sq_tail_q, tail_d;
  logic [3:0]        dw_idx_q, dw_d;
  logic [TAG_W-1:0]  batch_cnt_q, cnt_d;
  logic [QDEPTH-1:0] pend_q, pend_d;
  logic [31:0]       len_q, len_d;
  logic [TAG_W-1:0]  cid_q, cid_d;
  logic [14:0]       stat_q, stat_d;

  logic [31:0]       sqe_dword;
  logic [TAG_W-1:0]  cq_head, low_idx;
  logic              exp_phase, poll_expired, cqe_match;
  logic              cq_adv, cq_miss, cq_clr;
  logic              unused_cqe_bits;

  assign unused_cqe_bits = ^{mem_rd_data[95:32], mem_rd_data[111:96+TAG_W]};

  kvq_sqe_pack #(.TAG_W(TAG_W), .NSID(NSID)) u_pack (
    .req   (req_q),
    .cid   (sq_tail_q),
    .idx   (dw_idx_q),
    .dword (sqe_dword)
  );

  kvq_cq_ring #(.QDEPTH(QDEPTH), .POLL_LIMIT(POLL_LIMIT)) u_cq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .adv_i     (cq_adv),
    .miss_i    (cq_miss),
    .clr_i     (cq_clr),
    .head_o    (cq_head),
    .phase_o   (exp_phase),
    .expired_o (poll_expired)
  );

  kvq_lowest #(.N(QDEPTH)) u_low (
    .vec (pend_q),
    .idx (low_idx)
  );

  assign cqe_match = mem_rd_data[112] == exp_phase;
  assign cq_adv    = state_q == S_REPORT;
  assign cq_miss   = (state_q == S_POLL) && mem_rd_ack && !cqe_match && !poll_expired;
  assign cq_clr    = ((state_q == S_RING_SQ) && reg_wr_ack) ||
                     ((state_q == S_POLL) && mem_rd_ack && cqe_match);

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    last_d  = last_q;
    tail_d  = sq_tail_q;
    dw_d    = dw_idx_q;
    cnt_d   = batch_cnt_q;
    pend_d  = pend_q;
    len_d   = len_q;
    cid_d   = cid_q;
    stat_d  = stat_q;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        req_d.op      = req_op;
        req_d.key     = req_key;
        req_d.key_len = req_key_len;
        req_d.vsize   = req_value_size;
        req_d.dptr    = req_dptr;
        last_d        = req_last;
        dw_d          = '0;
        state_d       = S_BUILD;
      end
      S_BUILD: if (mem_wr_ack) begin
        if (dw_idx_q == 4'd15) begin
          pend_d[sq_tail_q] = 1'b1;
          tail_d = (sq_tail_q == TAG_W'(QDEPTH - 1)) ? '0 : sq_tail_q + 1'b1;
          if (last_q || batch_cnt_q == TAG_W'(QDEPTH - 2)) begin
            cnt_d   = '0;
            state_d = S_RING_SQ;
          end else begin
            cnt_d   = batch_cnt_q + 1'b1;
            state_d = S_IDLE;
          end
        end else begin
          dw_d = dw_idx_q + 4'd1;
        end
      end
      S_RING_SQ: if (reg_wr_ack) state_d = S_POLL;
      S_POLL: if (mem_rd_ack) begin
        if (cqe_match)         state_d = S_REREAD;
        else if (poll_expired) state_d = S_TIMEOUT;
      end
      S_REREAD: if (mem_rd_ack) begin
        len_d   = mem_rd_data[31:0];
        cid_d   = mem_rd_data[96 +: TAG_W];
        stat_d  = mem_rd_data[127:113];
        state_d = S_REPORT;
      end
      S_REPORT: begin
        pend_d[cid_q] = 1'b0;
        state_d = (HEAD_DB_EACH || pend_d == '0) ? S_RING_CQ : S_POLL;
      end
      S_RING_CQ: if (reg_wr_ack) state_d = (pend_q == '0) ? S_IDLE : S_POLL;
      S_TIMEOUT: begin
        pend_d[low_idx] = 1'b0;
        if (pend_d == '0) state_d = S_RING_CQ;
      end
      default: state_d = S_IDLE;
    endcase
  end

  logic ld_req, ld_cqe;
  assign ld_req = (state_q == S_IDLE) && req_valid;
  assign ld_cqe = (state_q == S_REREAD) && mem_rd_ack;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q     <= S_IDLE;
      req_q       <= '0;
      last_q      <= 1'b0;
      sq_tail_q   <= '0;
      dw_idx_q    <= '0;
      batch_cnt_q <= '0;
      pend_q      <= '0;
      len_q       <= '0;
      cid_q       <= '0;
      stat_q      <= '0;
    end else begin
      state_q     <= state_d;
      pend_q      <= pend_d;
      sq_tail_q   <= tail_d;
      dw_idx_q    <= dw_d;
      batch_cnt_q <= cnt_d;
      if (ld_req) req_q  <= req_d;
      if (ld_req) last_q <= last_d;
      if (ld_cqe) begin
        len_q  <= len_d;
        cid_q  <= cid_d;
        stat_q <= stat_d;
      end
    end
  end

  assign req_ready    = state_q == S_IDLE;
  assign mem_wr_valid = state_q == S_BUILD;
  assign mem_wr_addr  = SQ_BASE + 64'({sq_tail_q, dw_idx_q, 2'b00});
  assign mem_wr_data  = sqe_dword;
  assign mem_rd_valid = (state_q == S_POLL) || (state_q == S_REREAD);
  assign mem_rd_addr  = CQ_BASE + 64'({cq_head, 4'b0000});
  assign reg_wr_valid = (state_q == S_RING_SQ) || (state_q == S_RING_CQ);
  assign reg_wr_addr  = (state_q == S_RING_SQ) ? SQ_DB : CQ_DB;
  assign reg_wr_data  = (state_q == S_RING_SQ) ? 32'(sq_tail_q) : 32'(cq_head);
  assign rsp_valid    = (state_q == S_REPORT) || (state_q == S_TIMEOUT);
  assign rsp_timeout  = state_q == S_TIMEOUT;
  assign rsp_tag      = (state_q == S_TIMEOUT) ? low_idx : cid_q;
  assign rsp_len      = (state_q == S_REPORT) ? len_q : 32'd0;
  assign rsp_status   = (state_q == S_REPORT) ? stat_q : 15'd0;

  // R4: a submission write is held steady until it is acknowledged
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_wr_valid && !mem_wr_ack) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R6: a completion read is held steady until data returns
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R5: no request is taken while a doorbell write is pending
  p_no_accept_ring_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_wr_valid |-> !req_ready);

  // R7: every non-timeout report follows a second read of the entry
  p_reread_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && !rsp_timeout) |-> ($past(state_q) == S_REREAD));

  // R8: a reported tag belongs to a request still in flight
  p_tag_live_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_valid |-> pend_q[rsp_tag]);

endmodule

// File: tb/kv_queue_initiator_test.sv
module kv_queue_initiator_test;

  localparam int          QD  = 4;
  localparam int          QID = 8;
  localparam int          PL  = 12;
  localparam logic [31:0] NS  = 32'h0000_0005;
  localparam logic [63:0] SQB = 64'h1000;
  localparam logic [63:0] CQB = 64'h8000;
  localparam int          TW  = $clog2(QD);

  typedef struct packed {
    logic         op;
    logic [127:0] key;
    logic [4:0]   klen;
    logic [31:0]  vsz;
    logic [63:0]  addr;
    logic         last;
    logic         rev;
    logic         torn;
    logic [3:0]   delay;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{1'b0, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 5'd16, 32'd4096,
      64'h0000_0001_0000_0000, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 128'hDEADBEEF_CAFEF00D_89ABCDEF_012345A5, 5'd8, 32'd4096,
      64'h0000_0000_0004_0800, 1'b0, 1'b0, 1'b1, 4'd0},
    '{1'b1, 128'h11223344_55667788_99AABBCC_DDEEFF42, 5'd1, 32'd100,
      64'h0000_0000_0000_3000, 1'b0, 1'b0, 1'b0, 4'd1},
    '{1'b0, 128'h00000000_00000000_000000A1_B2C3D4E5, 5'd5, 32'd512,
      64'h0000_0002_0000_0FF0, 1'b0, 1'b0, 1'b0, 4'd0},
    '{1'b1, 128'h00000000_00000000_00000000_00C0FFEE, 5'd3, 32'd64,
      64'h0000_0000_0000_5000, 1'b1, 1'b1, 1'b0, 4'd3},
    '{1'b1, 128'h00000000_76543210_FEDCBA98_13579BDF, 5'd12, 32'd2048,
      64'h0000_0000_0000_7000, 1'b1, 1'b0, 1'b1, 4'd1}
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_op, req_last;
  logic [127:0] req_key;
  logic [4:0]   req_key_len;
  logic [31:0]  req_value_size;
  logic [63:0]  req_dptr;
  logic         mem_wr_valid, mem_wr_ack, mem_rd_valid, mem_rd_ack;
  logic [63:0]  mem_wr_addr, mem_rd_addr;
  logic [31:0]  mem_wr_data;
  logic [127:0] mem_rd_data;
  logic         reg_wr_valid, reg_wr_ack;
  logic [15:0]  reg_wr_addr;
  logic [31:0]  reg_wr_data;
  logic         rsp_valid, rsp_timeout;
  logic [TW-1:0] rsp_tag;
  logic [31:0]  rsp_len;
  logic [14:0]  rsp_status;

  kv_queue_initiator #(
    .QDEPTH(QD), .QID(QID), .NSID(NS), .SQ_BASE(SQB), .CQ_BASE(CQB),
    .POLL_LIMIT(PL), .HEAD_DB_EACH(1'b0)
  ) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // controller model state
  logic [31:0]  sqm [QD][16];
  logic [127:0] cqm [QD];
  logic         pv [QD];
  logic [127:0] pd [QD];
  int           pw [QD];
  logic         pt [QD];
  logic         torn_slot [QD];
  int           delay_slot [QD];
  int  m_sq_head = 0, m_cq_tail = 0;
  logic m_phase = 1'b1;
  logic kn_rev = 1'b0, kn_drop = 1'b0;

  int n_db = 0, n_rd = 0, r_n = 0;
  logic [15:0] db_a [64];
  logic [31:0] db_d [64];
  logic        db_rdy [64];
  logic [TW-1:0] r_tag [64];
  logic [31:0] r_len [64];
  logic [14:0] r_st [64];
  logic        r_to [64];

  task automatic post(input int nt);
    int cnt, k, s, c;
    logic [7:0] op, kl;
    logic [15:0] cid;
    logic [31:0] vz, ln;
    logic [14:0] st;
    logic miss;
    cnt = (nt - m_sq_head + QD) % QD;
    if (!kn_drop) begin
      for (int j = 0; j < cnt; j++) begin
        k  = kn_rev ? (cnt - 1 - j) : j;
        s  = (m_sq_head + k) % QD;
        op = sqm[s][0][7:0];
        cid = sqm[s][0][31:16];
        kl = sqm[s][11][7:0];
        vz = sqm[s][10];
        miss = (op == 8'h02) && (sqm[s][2][7:0] == 8'hEE);
        ln = (op == 8'h02 && !miss) ? vz - 32'(kl) : 32'd0;
        st = miss ? 15'h0087 : 15'h0000;
        c = m_cq_tail;
        pv[c] = 1'b1;
        pd[c] = {st, m_phase, cid, 16'(QID), 16'(nt), 32'd0, ln};
        pw[c] = delay_slot[s];
        pt[c] = torn_slot[s];
        m_cq_tail = (m_cq_tail + 1) % QD;
        if (m_cq_tail == 0) m_phase = ~m_phase;
      end
    end
    m_sq_head = nt;
  endtask

  // responders on the falling edge
  initial begin
    mem_wr_ack = 0; mem_rd_ack = 0; reg_wr_ack = 0; mem_rd_data = '0;
    for (int i = 0; i < QD; i++) begin
      cqm[i] = '0; pv[i] = 0; pw[i] = 0; pt[i] = 0;
      torn_slot[i] = 0; delay_slot[i] = 0;
    end
    forever begin
      @(negedge clk);
      if (mem_wr_valid && !mem_wr_ack) begin
        sqm[int'((mem_wr_addr - SQB) >> 6)][mem_wr_addr[5:2]] = mem_wr_data;
        mem_wr_ack = 1;
      end else mem_wr_ack = 0;
      if (mem_rd_valid && !mem_rd_ack) begin
        int c;
        c = int'((mem_rd_addr - CQB) >> 4);
        n_rd++;
        if (pv[c] && pw[c] > 0) begin
          pw[c]--;
          mem_rd_data = cqm[c];
        end else if (pv[c]) begin
          mem_rd_data = pt[c] ? {pd[c][127:32], cqm[c][31:0] & 32'd0} : pd[c];
          cqm[c] = pd[c];
          pv[c] = 0;
        end else mem_rd_data = cqm[c];
        mem_rd_ack = 1;
      end else mem_rd_ack = 0;
      if (reg_wr_valid && !reg_wr_ack) begin
        db_a[n_db] = reg_wr_addr;
        db_d[n_db] = reg_wr_data;
        db_rdy[n_db] = req_ready;
        n_db++;
        if (reg_wr_addr == 16'h1040) post(int'(reg_wr_data));
        reg_wr_ack = 1;
      end else reg_wr_ack = 0;
      if (rsp_valid) begin
        r_tag[r_n] = rsp_tag; r_len[r_n] = rsp_len;
        r_st[r_n] = rsp_status; r_to[r_n] = rsp_timeout;
        r_n++;
      end
    end
  end

  task automatic send(input vec_t v);
    @(negedge clk);
    req_valid = 1; req_op = v.op; req_key = v.key; req_key_len = v.klen;
    req_value_size = v.vsz; req_dptr = v.addr; req_last = v.last;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int tail = 0, head = 0;
  int bslot [4];
  int bvec  [4];

  initial begin
    int bn, db0, rd0, r0, dsum;
    logic [63:0] p2;
    rst_n = 0; req_valid = 0; req_op = 0; req_key = '0; req_key_len = '0;
    req_value_size = '0; req_dptr = '0; req_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(req_ready && !mem_wr_valid && !mem_rd_valid && !reg_wr_valid && !rsp_valid,
        "R11", {59'd0, req_ready, mem_wr_valid, mem_rd_valid, reg_wr_valid, rsp_valid},
        64'h10);

    bn = 0; db0 = 0; rd0 = 0; r0 = 0; dsum = 0;
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = VT[i];
      if (bn == 0) begin db0 = n_db; rd0 = n_rd; r0 = r_n; dsum = 0; end
      torn_slot[tail] = v.torn;
      delay_slot[tail] = int'(v.delay);
      kn_rev = v.rev;
      send(v);
      bslot[bn] = tail; bvec[bn] = i; bn++;
      dsum += int'(v.delay);
      tail = (tail + 1) % QD;
      if (v.last || bn == QD - 1) begin
        wait (r_n >= r0 + bn && n_db >= db0 + 2);
        repeat (3) @(negedge clk);
        // submission entry contents
        for (int k = 0; k < bn; k++) begin
          vec_t e;
          int s;
          e = VT[bvec[k]]; s = bslot[k];
          chk(sqm[s][0] == {16'(s), 8'h00, e.op ? 8'h02 : 8'h01}, "R1",
              64'(sqm[s][0]), 64'({16'(s), 8'h00, e.op ? 8'h02 : 8'h01}));
          chk(sqm[s][1] == NS, "R1", 64'(sqm[s][1]), 64'(NS));
          chk({sqm[s][15], sqm[s][14], sqm[s][3], sqm[s][2]} == e.key &&
              sqm[s][11] == 32'(e.klen), "R2",
              {sqm[s][3], sqm[s][2]}, e.key[63:0]);
          p2 = ((e.addr[11:0] + e.vsz) > 33'd4096) ?
               {e.addr[63:12] + 52'd1, 12'h000} : 64'd0;
          chk({sqm[s][7], sqm[s][6]} == e.addr && {sqm[s][9], sqm[s][8]} == p2 &&
              sqm[s][10] == e.vsz, "R3", {sqm[s][9], sqm[s][8]}, p2);
          chk((sqm[s][4] | sqm[s][5] | sqm[s][12] | sqm[s][13]) == 0, "R3",
              64'(sqm[s][4] | sqm[s][12]), 64'd0);
        end
        // doorbells: one tail write, one head write
        head = (head + bn) % QD;
        chk(n_db - db0 == 2, "R5", 64'(n_db - db0), 64'd2);
        chk(db_a[db0] == 16'h1040 && db_d[db0] == 32'(tail), "R5",
            {db_a[db0], db_d[db0]}, {16'h1040, 32'(tail)});
        chk(db_rdy[db0] == 1'b0, "R5", 64'(db_rdy[db0]), 64'd0);
        chk(db_a[db0+1] == 16'h1044 && db_d[db0+1] == 32'(head), "R9",
            {db_a[db0+1], db_d[db0+1]}, {16'h1044, 32'(head)});
        // reads: misses plus match plus second read
        chk(n_rd - rd0 == dsum + 2 * bn, "R7", 64'(n_rd - rd0), 64'(dsum + 2 * bn));
        // responses in completion order
        for (int k = 0; k < bn; k++) begin
          int kk;
          vec_t e;
          logic miss;
          logic [31:0] el;
          kk = v.rev ? (bn - 1 - k) : k;
          e = VT[bvec[kk]];
          miss = e.op && (e.key[7:0] == 8'hEE);
          el = (e.op && !miss) ? e.vsz - 32'(e.klen) : 32'd0;
          chk(r_tag[r0+k] == TW'(bslot[kk]) && !r_to[r0+k], "R8",
              64'(r_tag[r0+k]), 64'(bslot[kk]));
          chk(r_st[r0+k] == (miss ? 15'h0087 : 15'h0), "R8",
              64'(r_st[r0+k]), 64'(miss ? 15'h0087 : 15'h0));
          chk(r_len[r0+k] == el, e.torn ? "R7" : "R6", 64'(r_len[r0+k]), 64'(el));
        end
        bn = 0;
      end
    end

    // R10: two requests that never complete
    db0 = n_db; rd0 = n_rd; r0 = r_n;
    kn_drop = 1; kn_rev = 0;
    begin
      vec_t t;
      t = VT[2]; t.last = 0;
      send(t);
      t.last = 1;
      send(t);
    end
    wait (r_n >= r0 + 2 && n_db >= db0 + 2);
    repeat (3) @(negedge clk);
    chk(n_rd - rd0 == PL, "R10", 64'(n_rd - rd0), 64'(PL));
    chk(r_to[r0] && r_tag[r0] == TW'(tail), "R10", 64'(r_tag[r0]), 64'(tail));
    chk(r_to[r0+1] && r_tag[r0+1] == TW'((tail + 1) % QD), "R10",
        64'(r_tag[r0+1]), 64'((tail + 1) % QD));
    chk(db_a[db0+1] == 16'h1044 && db_d[db0+1] == 32'(head), "R10",
        {db_a[db0+1], db_d[db0+1]}, {16'h1044, 32'(head)});
    chk(req_ready == 1'b1, "R10", 64'(req_ready), 64'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule